// File: doc/BRIEF.md
# Dispatch Stall and Skid-Buffer Controller

This block sits between register rename and the issue and load/store queues of an out-of-order core. Each hardware thread has its own controller. Every cycle the controller takes up to `W` renamed instructions for each thread. Each instruction carries a tag and type bits saying whether it is a load, a store or an atomic. Using the free-entry counts the queues report, the controller forwards the instructions in order. When a thread cannot make progress, it parks instructions in a per-thread skid buffer and tells rename to stop with a one-cycle block pulse. Once the skid buffer has drained, it sends a one-cycle unblock pulse.

Each thread runs a five-state machine: running, idle, blocked, unblocking and squashing. A squash from commit empties the skid buffer and throws away the live input. While the reorder buffer is still squashing, live input keeps being thrown away. Discarded instructions are still reported in the per-cycle counts, so rename can return their credits. There are three counts: total instructions, instructions bound for the load queue, and instructions bound for the store queue.

The outputs are combinational in the current state and the current inputs. State changes on the rising edge of the clock.

Top module: `disp_stall_ctrl`

## Requirements
- R1: After reset every thread is running with an empty skid buffer. The block and unblock outputs are low, no lane is valid and all counts are zero.
- R2: Valid live lanes are packed from lane 0 upwards. An instruction kind has bit 0 for load, bit 1 for store and bit 2 for atomic, with at most one bit set. A running thread forwards its lanes in lane order on the same cycle. It reports the number forwarded, the number of loads, and the number of stores plus atomics.
- R3: Dispatch stops at the first instruction that finds no issue-queue entry, or that is a load with no load-queue entry, or that is a store or atomic with no store-queue entry. The undispatched instructions go to the skid buffer in order and the thread becomes blocked. Block pulses only if the thread was running or idle.
- R4: An issue-queue free count of zero stalls the thread. Nothing is dispatched and all live input goes to the skid buffer. Block pulses only if the thread was not already blocked or unblocking.
- R5: A blocked thread with no stall dispatches from the head of its skid buffer, oldest first, in the same cycle. Live input that cycle is appended behind the older entries.
- R6: If the skid buffer holds more than one cycle's width, the thread dispatches `W` entries and stays blocked, with no new block pulse and no unblock.
- R7: When an unblocking cycle leaves the skid buffer empty, unblock pulses and the thread dispatches live input directly from the next cycle.
- R8: A squash empties the skid buffer and discards the live input. Nothing is dispatched. Every discarded instruction is counted: all of them in the total, loads in the load count, and stores and atomics in the store count.
- R9: A squash pulses unblock if the thread was blocked or unblocking, and not otherwise.
- R10: While the reorder buffer is still squashing, live input is discarded with the same counting. No block or unblock is raised.
- R11: A squashing thread with neither squash input high dispatches live input normally in that same cycle.
- R12: A running thread with no input goes idle. An idle thread dispatches exactly like a running one and returns to running.
- R13: Threads are independent: one thread's stall, squash or skid state never changes another thread's dispatch.
- R14: The skid buffer holds up to `SKID_DEPTH` entries and returns all of them in order. An attempt to hold more is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_vld_i | input | NT*W | Live lane valid, thread-major |
| in_tag_i | input | NT*W*TAG_W | Live lane tag |
| in_kind_i | input | NT*W*3 | Live lane kind {atomic, store, load} |
| squash_i | input | NT | Squash from commit, per thread |
| rob_sq_i | input | NT | Reorder buffer still squashing, per thread |
| iq_free_i | input | NT*FW | Free issue-queue entries, per thread |
| lq_free_i | input | NT*FW | Free load-queue entries, per thread |
| sq_free_i | input | NT*FW | Free store-queue entries, per thread |
| out_vld_o | output | NT*W | Dispatched lane valid |
| out_tag_o | output | NT*W*TAG_W | Dispatched lane tag |
| out_kind_o | output | NT*W*3 | Dispatched lane kind |
| block_o | output | NT | Block pulse toward rename |
| unblock_o | output | NT | Unblock pulse toward rename |
| disp_cnt_o | output | NT*CW | Instructions dispatched or discarded this cycle |
| lq_cnt_o | output | NT*CW | Loads among them |
| sq_cnt_o | output | NT*CW | Stores and atomics among them |

## Verification
Two things can meet in one cycle: draining a stale skid buffer and discarding the live input. The bench fills the skid buffer under an issue-queue stall, then raises squash while new loads and stores are arriving. It checks that the counts cover both groups together and that unblock pulses. The bench also has a cycle where skid dispatch and re-blocking coincide. It fills the buffer to its full depth and then releases the stall, and checks that the oldest pair leaves while the thread stays blocked without a fresh block pulse.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_BLK   = 3'd2,
    ST_UNBLK = 3'd3,
    ST_SQ    = 3'd4
  } disp_state_e;

  localparam int KIND_W  = 3;
  localparam int K_LOAD  = 0;
  localparam int K_STORE = 1;
  localparam int K_ATOM  = 2;

  function automatic logic needs_lq(logic [KIND_W-1:0] k);
    return k[K_LOAD];
  endfunction

  function automatic logic needs_sq(logic [KIND_W-1:0] k);
    return k[K_STORE] | k[K_ATOM];
  endfunction
endpackage

// File: rtl/disp_skid_buf.sv
module disp_skid_buf
  import disp_pkg::*;
#(
  parameter int W     = 2,
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  localparam int IW   = $clog2(W+1),
  localparam int OW   = $clog2(DEPTH+1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic [IW-1:0]                 pop_n_i,
  input  logic [IW-1:0]                 push_n_i,
  input  logic [W-1:0][TAG_W-1:0]       push_tag_i,
  input  logic [W-1:0][KIND_W-1:0]      push_kind_i,
  output logic [OW-1:0]                 occ_o,
  output logic [W-1:0][TAG_W-1:0]       head_tag_o,
  output logic [DEPTH-1:0][KIND_W-1:0]  ent_kind_o
);
  logic [TAG_W-1:0]  mem_tag  [DEPTH];
  logic [KIND_W-1:0] mem_kind [DEPTH];
  logic [PW-1:0]     head_q;
  logic [OW-1:0]     occ_q;

  function automatic logic [PW-1:0] wrap(int v);
    int r;
    r = v;
    if (r >= DEPTH) r = r - DEPTH;
    if (r >= DEPTH) r = r - DEPTH;
    return PW'(r);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      occ_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      occ_q  <= '0;
    end else begin
      int nx;
      nx = int'(occ_q) - int'(pop_n_i) + int'(push_n_i);
      if (nx > DEPTH) nx = DEPTH;
      head_q <= wrap(int'(head_q) + int'(pop_n_i));
      occ_q  <= OW'(nx);
    end
  end

  // slots freed by this cycle's pop may be reused by this cycle's push
  always_ff @(posedge clk_i) begin
    for (int k = 0; k < W; k++) begin
      if (!flush_i && k < int'(push_n_i) &&
          int'(occ_q) + k < DEPTH + int'(pop_n_i)) begin
        mem_tag[wrap(int'(head_q) + int'(occ_q) + k)]  <= push_tag_i[k];
        mem_kind[wrap(int'(head_q) + int'(occ_q) + k)] <= push_kind_i[k];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) head_tag_o[i] = mem_tag[wrap(int'(head_q) + i)];
    for (int i = 0; i < DEPTH; i++) ent_kind_o[i] = mem_kind[wrap(int'(head_q) + i)];
  end

  assign occ_o = occ_q;
endmodule

// File: rtl/disp_pick.sv
module disp_pick
  import disp_pkg::*;
#(
  parameter int W  = 2,
  parameter int FW = 4,
  localparam int IW = $clog2(W+1)
) (
  input  logic [W-1:0]              src_vld_i,
  input  logic [W-1:0][KIND_W-1:0]  src_kind_i,
  input  logic [FW-1:0]             iq_free_i,
  input  logic [FW-1:0]             lq_free_i,
  input  logic [FW-1:0]             sq_free_i,
  output logic [IW-1:0]             take_o,
  output logic [IW-1:0]             nld_o,
  output logic [IW-1:0]             nsq_o
);
  always_comb begin
    logic [FW-1:0] iq, lq, sq;
    logic go, nl, ns;
    int t, cl, cs;
    iq = iq_free_i; lq = lq_free_i; sq = sq_free_i;
    go = 1'b1; t = 0; cl = 0; cs = 0;
    for (int k = 0; k < W; k++) begin
      nl = needs_lq(src_kind_i[k]);
      ns = needs_sq(src_kind_i[k]);
      if (!go || !src_vld_i[k]) begin
        go = 1'b0;
      end else if (iq == '0 || (nl && lq == '0) || (ns && sq == '0)) begin
        go = 1'b0;
      end else begin
        t  = t + 1;
        iq = iq - FW'(1);
        if (nl) begin lq = lq - FW'(1); cl = cl + 1; end
        if (ns) begin sq = sq - FW'(1); cs = cs + 1; end
      end
    end
    take_o = IW'(t);
    nld_o  = IW'(cl);
    nsq_o  = IW'(cs);
  end
endmodule

// File: rtl/disp_thread.sv
module disp_thread
  import disp_pkg::*;
#(
  parameter int W     = 2,
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int FW    = 4,
  parameter int CW    = 4,
  localparam int IW   = $clog2(W+1),
  localparam int OW   = $clog2(DEPTH+1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [W-1:0]              in_vld_i,
  input  logic [W-1:0][TAG_W-1:0]   in_tag_i,
  input  logic [W-1:0][KIND_W-1:0]  in_kind_i,
  input  logic                      squash_i,
  input  logic                      rob_sq_i,
  input  logic [FW-1:0]             iq_free_i,
  input  logic [FW-1:0]             lq_free_i,
  input  logic [FW-1:0]             sq_free_i,
  output logic [W-1:0]              out_vld_o,
  output logic [W-1:0][TAG_W-1:0]   out_tag_o,
  output logic [W-1:0][KIND_W-1:0]  out_kind_o,
  output logic                      block_o,
  output logic                      unblock_o,
  output logic [CW-1:0]             disp_cnt_o,
  output logic [CW-1:0]             lq_cnt_o,
  output logic [CW-1:0]             sq_cnt_o,
  output logic [OW-1:0]             skid_occ_o,
  output logic [IW-1:0]             skid_push_o,
  output logic [IW-1:0]             skid_pop_o
);
  disp_state_e st_q, st_d, eff;

  logic                         flush;
  logic [IW-1:0]                pop_n, push_n;
  logic [W-1:0][TAG_W-1:0]      push_tag;
  logic [W-1:0][KIND_W-1:0]     push_kind;
  logic [OW-1:0]                occ;
  logic [W-1:0][TAG_W-1:0]      head_tag;
  logic [DEPTH-1:0][KIND_W-1:0] ent_kind;
  logic [W-1:0]                 src_vld;
  logic [W-1:0][TAG_W-1:0]      src_tag;
  logic [W-1:0][KIND_W-1:0]     src_kind;
  logic [IW-1:0]                take_n, nld, nsq;
  int                           live;

  disp_skid_buf #(.W(W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_skid (
    .clk_i, .rst_ni,
    .flush_i     (flush),
    .pop_n_i     (pop_n),
    .push_n_i    (push_n),
    .push_tag_i  (push_tag),
    .push_kind_i (push_kind),
    .occ_o       (occ),
    .head_tag_o  (head_tag),
    .ent_kind_o  (ent_kind)
  );

  // blocked with no stall is treated as unblocking; squashing as running
  always_comb begin
    live = 0;
    for (int k = 0; k < W; k++) if (in_vld_i[k]) live = live + 1;
    case (st_q)
      ST_BLK:  eff = ST_UNBLK;
      ST_SQ:   eff = ST_RUN;
      default: eff = st_q;
    endcase
    for (int k = 0; k < W; k++) begin
      if (eff == ST_UNBLK) begin
        src_vld[k]  = (k < int'(occ));
        src_tag[k]  = head_tag[k];
        src_kind[k] = ent_kind[k];
      end else begin
        src_vld[k]  = in_vld_i[k];
        src_tag[k]  = in_tag_i[k];
        src_kind[k] = in_kind_i[k];
      end
    end
  end

  disp_pick #(.W(W), .FW(FW)) u_pick (
    .src_vld_i  (src_vld),
    .src_kind_i (src_kind),
    .iq_free_i,
    .lq_free_i,
    .sq_free_i,
    .take_o     (take_n),
    .nld_o      (nld),
    .nsq_o      (nsq)
  );

  always_comb begin
    int take, srcn, nd, nl, ns;
    logic was_blk;
    take    = int'(take_n);
    srcn    = (eff == ST_UNBLK) ? int'(occ) : live;
    was_blk = (st_q == ST_BLK) || (st_q == ST_UNBLK);
    st_d      = st_q;
    flush     = 1'b0;
    pop_n     = '0;
    push_n    = '0;
    push_tag  = in_tag_i;
    push_kind = in_kind_i;
    out_vld_o = '0;
    out_tag_o = src_tag;
    out_kind_o = src_kind;
    block_o   = 1'b0;
    unblock_o = 1'b0;
    nd = 0; nl = 0; ns = 0;

    if (squash_i) begin
      flush     = 1'b1;
      unblock_o = was_blk;
      st_d      = ST_SQ;
      for (int i = 0; i < DEPTH; i++) begin
        if (i < int'(occ)) begin
          nd = nd + 1;
          if (needs_lq(ent_kind[i])) nl = nl + 1;
          if (needs_sq(ent_kind[i])) ns = ns + 1;
        end
      end
      for (int k = 0; k < W; k++) begin
        if (in_vld_i[k]) begin
          nd = nd + 1;
          if (needs_lq(in_kind_i[k])) nl = nl + 1;
          if (needs_sq(in_kind_i[k])) ns = ns + 1;
        end
      end
    end else if (rob_sq_i) begin
      st_d = ST_SQ;
      for (int k = 0; k < W; k++) begin
        if (in_vld_i[k]) begin
          nd = nd + 1;
          if (needs_lq(in_kind_i[k])) nl = nl + 1;
          if (needs_sq(in_kind_i[k])) ns = ns + 1;
        end
      end
    end else if (iq_free_i == '0) begin
      push_n  = IW'(live);
      st_d    = ST_BLK;
      block_o = !was_blk;
    end else begin
      for (int k = 0; k < W; k++) out_vld_o[k] = (k < take);
      nd = take;
      nl = int'(nld);
      ns = int'(nsq);
      if (eff == ST_UNBLK) begin
        pop_n  = take_n;
        push_n = IW'(live);
      end else begin
        push_n = IW'(live - take);
        for (int k = 0; k < W; k++) begin
          if (k + take < W) begin
            push_tag[k]  = in_tag_i[k + take];
            push_kind[k] = in_kind_i[k + take];
          end
        end
      end
      if (srcn > take) begin
        st_d    = ST_BLK;
        block_o = (eff != ST_UNBLK);
      end else if (eff == ST_UNBLK) begin
        if (int'(occ) - take + live == 0) begin
          unblock_o = 1'b1;
          st_d      = ST_RUN;
        end else begin
          st_d = ST_UNBLK;
        end
      end else begin
        st_d = (live == 0) ? ST_IDLE : ST_RUN;
      end
    end
    disp_cnt_o = CW'(nd);
    lq_cnt_o   = CW'(nl);
    sq_cnt_o   = CW'(ns);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign skid_occ_o  = occ;
  assign skid_push_o = push_n;
  assign skid_pop_o  = pop_n;
endmodule

// File: rtl/disp_stall_ctrl.sv
module disp_stall_ctrl
  import disp_pkg::*;
#(
  parameter int NT         = 2,
  parameter int W          = 2,
  parameter int SKID_DEPTH = 8,
  parameter int TAG_W      = 8,
  parameter int FW         = 4,
  localparam int CW        = $clog2(SKID_DEPTH+W+1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NT*W-1:0]          in_vld_i,
  input  logic [NT*W*TAG_W-1:0]    in_tag_i,
  input  logic [NT*W*3-1:0]        in_kind_i,
  input  logic [NT-1:0]            squash_i,
  input  logic [NT-1:0]            rob_sq_i,
  input  logic [NT*FW-1:0]         iq_free_i,
  input  logic [NT*FW-1:0]         lq_free_i,
  input  logic [NT*FW-1:0]         sq_free_i,
  output logic [NT*W-1:0]          out_vld_o,
  output logic [NT*W*TAG_W-1:0]    out_tag_o,
  output logic [NT*W*3-1:0]        out_kind_o,
  output logic [NT-1:0]            block_o,
  output logic [NT-1:0]            unblock_o,
  output logic [NT*CW-1:0]         disp_cnt_o,
  output logic [NT*CW-1:0]         lq_cnt_o,
  output logic [NT*CW-1:0]         sq_cnt_o
);
  localparam int IW = $clog2(W+1);
  localparam int OW = $clog2(SKID_DEPTH+1);

  logic [NT*OW-1:0] skid_occ;
  logic [NT*IW-1:0] skid_push;
  logic [NT*IW-1:0] skid_pop;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    disp_thread #(
      .W(W), .DEPTH(SKID_DEPTH), .TAG_W(TAG_W), .FW(FW), .CW(CW)
    ) u_thr (
      .clk_i,
      .rst_ni,
      .in_vld_i    (in_vld_i[t*W +: W]),
      .in_tag_i    (in_tag_i[t*W*TAG_W +: W*TAG_W]),
      .in_kind_i   (in_kind_i[t*W*3 +: W*3]),
      .squash_i    (squash_i[t]),
      .rob_sq_i    (rob_sq_i[t]),
      .iq_free_i   (iq_free_i[t*FW +: FW]),
      .lq_free_i   (lq_free_i[t*FW +: FW]),
      .sq_free_i   (sq_free_i[t*FW +: FW]),
      .out_vld_o   (out_vld_o[t*W +: W]),
      .out_tag_o   (out_tag_o[t*W*TAG_W +: W*TAG_W]),
      .out_kind_o  (out_kind_o[t*W*3 +: W*3]),
      .block_o     (block_o[t]),
      .unblock_o   (unblock_o[t]),
      .disp_cnt_o  (disp_cnt_o[t*CW +: CW]),
      .lq_cnt_o    (lq_cnt_o[t*CW +: CW]),
      .sq_cnt_o    (sq_cnt_o[t*CW +: CW]),
      .skid_occ_o  (skid_occ[t*OW +: OW]),
      .skid_push_o (skid_push[t*IW +: IW]),
      .skid_pop_o  (skid_pop[t*IW +: IW])
    );
  end
endmodule

// File: rtl/disp_stall_ctrl_chk.sv
module disp_stall_ctrl_chk #(
  parameter int NT = 2,
  parameter int W  = 2,
  parameter int DEPTH = 8,
  parameter int FW = 4,
  parameter int CW = 4,
  parameter int OW = 4,
  parameter int IW = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NT-1:0]     squash_i,
  input logic [NT-1:0]     rob_sq_i,
  input logic [NT*FW-1:0]  iq_free_i,
  input logic [NT*FW-1:0]  lq_free_i,
  input logic [NT*FW-1:0]  sq_free_i,
  input logic [NT*W-1:0]   out_vld_o,
  input logic [NT-1:0]     block_o,
  input logic [NT-1:0]     unblock_o,
  input logic [NT*CW-1:0]  disp_cnt_o,
  input logic [NT*CW-1:0]  lq_cnt_o,
  input logic [NT*CW-1:0]  sq_cnt_o,
  input logic [NT*OW-1:0]  skid_occ,
  input logic [NT*IW-1:0]  skid_push,
  input logic [NT*IW-1:0]  skid_pop
);
  for (genvar t = 0; t < NT; t++) begin : g_chk
    // R4
    stall_no_disp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iq_free_i[t*FW +: FW] == '0) |-> (out_vld_o[t*W +: W] == '0));
    // R8
    squash_no_disp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (squash_i[t] || rob_sq_i[t]) |-> (out_vld_o[t*W +: W] == '0));
    // R8
    squash_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      squash_i[t] |-> (int'(lq_cnt_o[t*CW +: CW]) + int'(sq_cnt_o[t*CW +: CW])
                       <= int'(disp_cnt_o[t*CW +: CW])));
    // R3
    budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(squash_i[t] || rob_sq_i[t]) |->
        (int'(disp_cnt_o[t*CW +: CW]) <= int'(iq_free_i[t*FW +: FW]) &&
         int'(lq_cnt_o[t*CW +: CW])   <= int'(lq_free_i[t*FW +: FW]) &&
         int'(sq_cnt_o[t*CW +: CW])   <= int'(sq_free_i[t*FW +: FW])));
    // R9
    hs_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(block_o[t] && unblock_o[t]));
    // R4
    block_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      block_o[t] |=> !block_o[t]);
    // R14
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(skid_occ[t*OW +: OW]) + int'(skid_push[t*IW +: IW])
       - int'(skid_pop[t*IW +: IW])) <= DEPTH);
    for (genvar k = 0; k + 1 < W; k++) begin : g_pack
      // R2
      packed_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_vld_o[t*W+k+1] |-> out_vld_o[t*W+k]);
    end
  end
endmodule

bind disp_stall_ctrl disp_stall_ctrl_chk #(
  .NT(NT), .W(W), .DEPTH(SKID_DEPTH), .FW(FW), .CW(CW), .OW(OW), .IW(IW)
) u_chk (
  .clk_i, .rst_ni, .squash_i, .rob_sq_i, .iq_free_i, .lq_free_i, .sq_free_i,
  .out_vld_o, .block_o, .unblock_o, .disp_cnt_o, .lq_cnt_o, .sq_cnt_o,
  .skid_occ, .skid_push, .skid_pop
);

// File: tb/disp_stall_ctrl_tb_top.sv
`timescale 1ns/1ps
module disp_stall_ctrl_tb_top;
  localparam int NT = 2, W = 2, DEPTH = 8, TAG_W = 8, FW = 4;
  localparam int CW = $clog2(DEPTH+W+1);
  localparam real CLK_P = 8.0;
  localparam logic [2:0] K_ALU = 3'b000, K_LD = 3'b001, K_ST = 3'b010, K_AT = 3'b100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT*W-1:0]       in_vld;
  logic [NT*W*TAG_W-1:0] in_tag;
  logic [NT*W*3-1:0]     in_kind;
  logic [NT-1:0]         squash, rob_sq;
  logic [NT*FW-1:0]      iq_free, lq_free, sq_free;
  logic [NT*W-1:0]       out_vld;
  logic [NT*W*TAG_W-1:0] out_tag;
  logic [NT*W*3-1:0]     out_kind;
  logic [NT-1:0]         blk, unblk;
  logic [NT*CW-1:0]      dcnt_v, lcnt_v, scnt_v;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  disp_stall_ctrl #(.NT(NT), .W(W), .SKID_DEPTH(DEPTH), .TAG_W(TAG_W), .FW(FW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .in_tag_i(in_tag), .in_kind_i(in_kind),
    .squash_i(squash), .rob_sq_i(rob_sq), .iq_free_i(iq_free), .lq_free_i(lq_free),
    .sq_free_i(sq_free), .out_vld_o(out_vld), .out_tag_o(out_tag), .out_kind_o(out_kind),
    .block_o(blk), .unblock_o(unblk), .disp_cnt_o(dcnt_v), .lq_cnt_o(lcnt_v), .sq_cnt_o(scnt_v)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int vld(int t);  return int'(out_vld[t*W +: W]); endfunction
  function automatic int tag(int t, int k); return int'(out_tag[(t*W+k)*TAG_W +: TAG_W]); endfunction
  function automatic int dc(int t);   return int'(dcnt_v[t*CW +: CW]); endfunction
  function automatic int lc(int t);   return int'(lcnt_v[t*CW +: CW]); endfunction
  function automatic int sc(int t);   return int'(scnt_v[t*CW +: CW]); endfunction

  task automatic clr_in();
    in_vld = '0; in_tag = '0; in_kind = '0; squash = '0; rob_sq = '0;
  endtask

  task automatic put(int t, int k, int tg, logic [2:0] kd);
    in_vld[t*W+k] = 1'b1;
    in_tag[(t*W+k)*TAG_W +: TAG_W] = TAG_W'(tg);
    in_kind[(t*W+k)*3 +: 3] = kd;
  endtask

  task automatic set_free(int t, int iq, int lq, int sq);
    iq_free[t*FW +: FW] = FW'(iq);
    lq_free[t*FW +: FW] = FW'(lq);
    sq_free[t*FW +: FW] = FW'(sq);
  endtask

  // after inputs are set at a falling edge: settle, then check before rising edge
  task automatic settle(); #1; endtask
  task automatic next_cyc(); @(posedge clk); @(negedge clk); clr_in(); endtask

  task automatic t_reset();
    settle();
    for (int t = 0; t < NT; t++) begin
      chk("R1 block", int'(blk[t]), 0);
      chk("R1 unblock", int'(unblk[t]), 0);
      chk("R1 vld", vld(t), 0);
      chk("R1 dcnt", dc(t), 0);
    end
    next_cyc();
  endtask

  task automatic t_pass();
    put(0, 0, 10, K_LD); put(0, 1, 11, K_ST); settle();
    chk("R2 vld", vld(0), 3); chk("R2 tag0", tag(0,0), 10); chk("R2 tag1", tag(0,1), 11);
    chk("R2 dcnt", dc(0), 2); chk("R2 lcnt", lc(0), 1); chk("R2 scnt", sc(0), 1);
    chk("R1 no block", int'(blk[0]), 0);
    next_cyc();
  endtask

  task automatic t_idle();
    settle(); chk("R12 empty vld", vld(0), 0);
    next_cyc();
    put(0, 0, 12, K_ALU); settle();
    chk("R12 idle vld", vld(0), 1); chk("R12 idle tag", tag(0,0), 12); chk("R12 dcnt", dc(0), 1);
    next_cyc();
  endtask

  task automatic t_lq_full();
    set_free(0, 4, 1, 4);
    put(0, 0, 20, K_LD); put(0, 1, 21, K_LD); settle();
    chk("R3 vld", vld(0), 1); chk("R3 tag", tag(0,0), 20); chk("R3 block", int'(blk[0]), 1);
    chk("R3 lcnt", lc(0), 1);
    next_cyc();
    set_free(0, 4, 4, 4); put(0, 0, 22, K_ALU); settle();
    chk("R5 skid first", tag(0,0), 21); chk("R5 vld", vld(0), 1);
    chk("R5 unblock", int'(unblk[0]), 0); chk("R5 block", int'(blk[0]), 0);
    next_cyc();
    settle();
    chk("R7 live behind", tag(0,0), 22); chk("R7 unblock", int'(unblk[0]), 1);
    next_cyc();
    put(0, 0, 23, K_ST); settle();
    chk("R7 running tag", tag(0,0), 23); chk("R7 scnt", sc(0), 1);
    next_cyc();
  endtask

  task automatic t_sq_full();
    set_free(0, 4, 4, 0);
    put(0, 0, 30, K_ALU); put(0, 1, 31, K_AT); settle();
    chk("R3 at vld", vld(0), 1); chk("R3 at block", int'(blk[0]), 1); chk("R3 at scnt", sc(0), 0);
    next_cyc();
    set_free(0, 4, 4, 4); settle();
    chk("R3 at tag", tag(0,0), 31); chk("R3 at scnt2", sc(0), 1); chk("R7 at unblock", int'(unblk[0]), 1);
    next_cyc();
  endtask

  task automatic t_stall_fill();
    set_free(0, 0, 4, 4);
    for (int c = 0; c < 4; c++) begin
      put(0, 0, 40 + 2*c, K_ALU); put(0, 1, 41 + 2*c, K_ALU);
      if (c == 1) begin put(1, 0, 90, K_LD); put(1, 1, 91, K_ALU); end
      settle();
      chk("R4 no disp", vld(0), 0);
      chk("R4 block once", int'(blk[0]), (c == 0) ? 1 : 0);
      if (c == 1) begin
        chk("R13 other vld", vld(1), 3); chk("R13 other tag", tag(1,1), 91);
        chk("R13 other block", int'(blk[1]), 0);
      end
      next_cyc();
    end
    set_free(0, 4, 4, 4);
    for (int c = 0; c < 4; c++) begin
      settle();
      chk("R14 tag0", tag(0,0), 40 + 2*c); chk("R14 tag1", tag(0,1), 41 + 2*c);
      chk("R6 vld", vld(0), 3); chk("R6 block", int'(blk[0]), 0);
      chk("R6 unblock", int'(unblk[0]), (c == 3) ? 1 : 0);
      next_cyc();
    end
  endtask

  task automatic t_squash();
    set_free(0, 0, 4, 4);
    put(0, 0, 50, K_LD); put(0, 1, 51, K_AT); settle();
    chk("R4 block", int'(blk[0]), 1);
    next_cyc();
    squash[0] = 1'b1; put(0, 0, 52, K_ST); put(0, 1, 53, K_LD); settle();
    chk("R8 dcnt", dc(0), 4); chk("R8 lcnt", lc(0), 2); chk("R8 scnt", sc(0), 2);
    chk("R8 vld", vld(0), 0); chk("R9 unblock", int'(unblk[0]), 1);
    next_cyc();
    rob_sq[0] = 1'b1; put(0, 0, 54, K_LD); settle();
    chk("R10 dcnt", dc(0), 1); chk("R10 lcnt", lc(0), 1); chk("R10 vld", vld(0), 0);
    chk("R10 unblock", int'(unblk[0]), 0); chk("R10 block", int'(blk[0]), 0);
    next_cyc();
    set_free(0, 4, 4, 4); put(0, 0, 55, K_ST); settle();
    chk("R11 vld", vld(0), 1); chk("R11 tag", tag(0,0), 55); chk("R11 scnt", sc(0), 1);
    next_cyc();
    squash[0] = 1'b1; put(0, 0, 60, K_ALU); settle();
    chk("R9 running no unblock", int'(unblk[0]), 0); chk("R8 run dcnt", dc(0), 1);
    chk("R8 run vld", vld(0), 0);
    next_cyc();
    put(0, 0, 61, K_LD); settle();
    chk("R11 after squash", tag(0,0), 61); chk("R11 lcnt", lc(0), 1);
    next_cyc();
  endtask

  initial begin
    clr_in();
    for (int t = 0; t < NT; t++) set_free(t, 4, 4, 4);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_pass();
    t_idle();
    t_lq_full();
    t_sq_full();
    t_stall_fill();
    t_squash();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule